// File: doc/BRIEF.md
# SPI Receive Status and Interrupt Flags

This block keeps the receive-side status of a serial peripheral. The shift engine hands it each finished byte as a one-cycle valid pulse with the byte. The CPU side gives it one-cycle strobes for a status-register read, a data-register read and a control-register write, and it returns the status value and the held byte. Three flags are kept: receive-full, overrun and mode-fault. All three feed one interrupt request line.

A flag is cleared in two steps. First the CPU reads the status register while the flag is set, which arms the clear for that flag. Then the matching second access completes the clear: a data read clears receive-full and overrun, and a control write clears mode-fault. When a byte arrives while the held byte is still unread, the new byte is discarded and overrun is raised. The unread older byte stays in the data register. Enable bits arrive as plain inputs.

The byte input has no back-pressure and no ready signal. Every valid pulse is taken in the cycle it appears, either loaded into the data register or dropped with overrun raised. Reset is synchronous and active high.

Top module: `spi_rx_status`

## Requirements
- R1: Synchronous reset clears all flags, sets the data register to 0, and drives the interrupt low.
- R2: A byte arriving while receive-full is clear is loaded into the data register, and receive-full reads 1 from the next cycle.
- R3: A byte arriving while receive-full is set, when no clearing data read happens in that cycle, sets overrun and is discarded. The data register keeps the older byte.
- R4: Receive-full clears only after a data read that follows a status read made while receive-full was set. A data read with no such armed status read leaves it set.
- R5: Overrun clears after a status read made while it was set, followed by a data read. That data read sees the older retained byte.
- R6: A status read arms the clear only for flags set at that read. A flag that becomes set between the status read and the data read survives that data read.
- R7: Mode-fault is set by the fault-detect input only while the mode-fault enable is 1.
- R8: Mode-fault clears after a status read made while it was set, followed by a control write. A control write with no armed status read does not clear it. Dropping the enable does not clear it, and with the enable at 0 a cleared flag is not set again.
- R9: The interrupt is (receive-full AND receiver-interrupt enable) OR (error-interrupt enable AND (overrun OR mode-fault)).
- R10: Status layout: bit 7 is receive-full, bit 6 is overrun, bit 4 is mode-fault, and all other bits are 0.
- R11: A byte arriving in the same cycle as a data read that clears receive-full is loaded. Receive-full stays 1 and overrun stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle pulse: a byte has finished shifting in |
| rx_byte | input | DATA_W | Received byte that goes with rx_valid |
| fault_det | input | 1 | Mode-fault condition from the select logic |
| fault_en | input | 1 | Mode-fault enable |
| rx_irq_en | input | 1 | Receive-full interrupt enable |
| err_irq_en | input | 1 | Shared error interrupt enable for overrun and mode-fault |
| stat_rd | input | 1 | CPU read of the status register |
| data_rd | input | 1 | CPU read of the data register |
| ctrl_wr | input | 1 | CPU write of the control register |
| status | output | 8 | Status register value |
| data_q | output | DATA_W | Data register value |
| irq | output | 1 | Shared receiver and error interrupt request |

## Verification
The bench builds the block with the default 8-bit data width, so byte values such as 0xA5 and 0x66 can be compared directly at the data port. Each scenario drives a read sequence at cycle level. This covers the timing-sensitive cases: a byte that lands between the arming status read and the data read, and a byte that lands in the same cycle as the clearing read. The bench also walks the mode-fault enable through set, disable and clear, and checks each term of the interrupt separately.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_FULL = 7;
  localparam int BIT_OVR  = 6;
  localparam int BIT_MODF = 4;

  typedef struct packed {
    logic full;
    logic ovr;
    logic modf;
  } rxs_flags_t;
endpackage

// File: rtl/spi_rxs_datapath.sv
module spi_rxs_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic              full_q,
  output logic              ovr_q,
  output logic [DATA_W-1:0] data_q
);
  logic full_arm, ovr_arm;
  logic clr_full, clr_ovr, free;

  assign clr_full = data_rd && full_arm;
  assign clr_ovr  = data_rd && ovr_arm;
  assign free     = !full_q || clr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      data_q   <= '0;
      full_arm <= 1'b0;
      ovr_arm  <= 1'b0;
    end else begin
      if (rx_valid && free) begin
        data_q <= rx_byte;
        full_q <= 1'b1;
      end else if (clr_full) begin
        full_q <= 1'b0;
      end

      if (rx_valid && !free)  ovr_q <= 1'b1;
      else if (clr_ovr)       ovr_q <= 1'b0;

      if (stat_rd && full_q)  full_arm <= 1'b1;
      else if (data_rd)       full_arm <= 1'b0;

      if (stat_rd && ovr_q)   ovr_arm <= 1'b1;
      else if (data_rd)       ovr_arm <= 1'b0;
    end
  end

  // R2 / R11: an accepted byte lands in the data register
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (!full_q || clr_full)) |=> (full_q && data_q == $past(rx_byte)));

  // R3: a dropped byte leaves the held byte untouched
  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && full_q && !clr_full) |=> (ovr_q && $stable(data_q)));

  // R4: receive-full is held while no data read happens
  p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (full_q && !data_rd) |=> full_q);

  // R5: overrun survives any cycle without a data read
  p_ovr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !data_rd) |=> ovr_q);
endmodule

// File: rtl/spi_rxs_modf.sv
module spi_rxs_modf (
  input  logic clk,
  input  logic rst,
  input  logic fault_det,
  input  logic fault_en,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic modf_q
);
  logic modf_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      modf_q   <= 1'b0;
      modf_arm <= 1'b0;
    end else begin
      if (fault_det && fault_en)       modf_q <= 1'b1;
      else if (ctrl_wr && modf_arm)    modf_q <= 1'b0;

      if (stat_rd && modf_q)           modf_arm <= 1'b1;
      else if (ctrl_wr)                modf_arm <= 1'b0;
    end
  end

  // R7: with the enable low, a clear flag stays clear
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!modf_q && !fault_en) |=> !modf_q);

  // R8: the flag holds while no control write happens
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (modf_q && !ctrl_wr) |=> modf_q);
endmodule

// File: rtl/spi_rxs_irq.sv
module spi_rxs_irq (
  input  spi_rxs_pkg::rxs_flags_t flags,
  input  logic                    rx_irq_en,
  input  logic                    err_irq_en,
  output logic                    irq
);
  logic rx_term, err_term;

  assign rx_term  = flags.full & rx_irq_en;
  assign err_term = err_irq_en & (flags.ovr | flags.modf);
  assign irq      = rx_term | err_term;

  // R9: with both enables low there is no request
  always_comb begin
    p_quiet_r9: assert (!((!rx_irq_en && !err_irq_en) && irq));
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              fault_det,
  input  logic              fault_en,
  input  logic              rx_irq_en,
  input  logic              err_irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] data_q,
  output logic              irq
);
  import spi_rxs_pkg::*;

  rxs_flags_t flags;
  logic full_q, ovr_q, modf_q;

  spi_rxs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .stat_rd(stat_rd), .data_rd(data_rd),
    .full_q(full_q), .ovr_q(ovr_q), .data_q(data_q)
  );

  spi_rxs_modf u_modf (
    .clk(clk), .rst(rst), .fault_det(fault_det), .fault_en(fault_en),
    .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .modf_q(modf_q)
  );

  assign flags.full = full_q;
  assign flags.ovr  = ovr_q;
  assign flags.modf = modf_q;

  spi_rxs_irq u_irq (
    .flags(flags), .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .irq(irq)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == BIT_FULL)      begin : g_full assign status[b] = flags.full; end
    else if (b == BIT_OVR)  begin : g_ovr  assign status[b] = flags.ovr;  end
    else if (b == BIT_MODF) begin : g_modf assign status[b] = flags.modf; end
    else                    begin : g_zero assign status[b] = 1'b0;       end
  end

  // R9: an enabled error flag always raises the request
  p_err_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (err_irq_en && (status[BIT_OVR] || status[BIT_MODF])) |-> irq);

  // R1: the cycle after reset all flags read clear
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (status == 8'h00 && !irq));
endmodule

// File: tb/sim_spi_rx_status.sv
module sim_spi_rx_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, fault_det = 0, fault_en = 0, rx_irq_en = 0, err_irq_en = 0;
  logic stat_rd = 0, data_rd = 0, ctrl_wr = 0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] status, data_q;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_rx_status #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .fault_det(fault_det), .fault_en(fault_en), .rx_irq_en(rx_irq_en),
    .err_irq_en(err_irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .ctrl_wr(ctrl_wr), .status(status), .data_q(data_q), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rx_valid = 0; stat_rd = 0; data_rd = 0; ctrl_wr = 0; fault_det = 0;
  endtask

  task automatic send(logic [7:0] b);
    rx_valid = 1; rx_byte = b; step();
  endtask

  task automatic clear_rx();
    stat_rd = 1; step();
    data_rd = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 data", data_q, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_load();
    send(8'hA5);
    chk("R2 R10 status", status, 8'h80);
    chk("R2 data", data_q, 8'hA5);
    rx_irq_en = 1; #1;
    chk("R9 rx irq on", irq, 1);
    rx_irq_en = 0; #1;
    chk("R9 rx irq off", irq, 0);
  endtask

  task automatic t_noarm();
    data_rd = 1; step();
    chk("R4 unarmed read", status, 8'h80);
    clear_rx();
    chk("R4 cleared", status, 8'h00);
  endtask

  task automatic t_overrun();
    send(8'h11);
    send(8'h22);
    chk("R3 R10 status", status, 8'hC0);
    chk("R3 data kept", data_q, 8'h11);
    err_irq_en = 1; #1;
    chk("R9 ovr irq", irq, 1);
    err_irq_en = 0;
    stat_rd = 1; step();
    data_rd = 1; #1;
    chk("R5 read value", data_q, 8'h11);
    step();
    chk("R5 cleared", status, 8'h00);
  endtask

  task automatic t_late();
    send(8'h33);
    stat_rd = 1; step();
    send(8'h44);
    chk("R6 both set", status, 8'hC0);
    data_rd = 1; step();
    chk("R6 ovr survives", status, 8'h40);
    chk("R6 data", data_q, 8'h33);
    clear_rx();
    chk("R6 final clear", status, 8'h00);
  endtask

  task automatic t_same();
    send(8'h55);
    stat_rd = 1; step();
    data_rd = 1; rx_valid = 1; rx_byte = 8'h66; step();
    chk("R11 status", status, 8'h80);
    chk("R11 data", data_q, 8'h66);
    clear_rx();
    chk("R11 clean", status, 8'h00);
  endtask

  task automatic t_modf();
    fault_en = 0; fault_det = 1; step();
    chk("R7 gated", status, 8'h00);
    fault_en = 1; fault_det = 1; step();
    chk("R7 R10 set", status, 8'h10);
    fault_en = 0;
    ctrl_wr = 1; step();
    chk("R8 unarmed write", status, 8'h10);
    chk("R8 enable drop keeps", status[4], 1);
    err_irq_en = 1; #1;
    chk("R9 modf irq", irq, 1);
    err_irq_en = 0; #1;
    chk("R9 modf irq off", irq, 0);
    stat_rd = 1; step();
    ctrl_wr = 1; step();
    chk("R8 cleared", status, 8'h00);
    fault_det = 1; step();
    chk("R8 no reset with en low", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_load();
    t_noarm();
    t_overrun();
    t_late();
    t_same();
    t_modf();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule